// File: doc/BRIEF.md
# Wormhole Output-Port Packet Arbiter

This block allocates one output port of a wormhole router among several input ports. Each input offers a request, the two-bit kind of the flit at its head, and a one-bit faction tag. A packet wins the port only with its header flit. The winner then keeps the port for every later flit of its packet, and gives it up on the cycle its tail flit is handed over. The bench-side `flit_fire` input marks the cycle in which the granted flit actually moves through the port.

The control is a two-state machine. `ST_IDLE` means no packet owns the port. `ST_LOCKED` means one requester owns it. The transition `T_ACQUIRE` (`ST_IDLE` to `ST_LOCKED`) is taken when any eligible header request is present; the chosen requester is stored as the grant. The transition `T_RELEASE` (`ST_LOCKED` to `ST_IDLE`) is taken when `flit_fire` coincides with a last or single flit from the owner. Otherwise each state holds (`T_WAIT` in idle, `T_HOLD` when locked). The selection policy is fixed at elaboration: round robin, least recently served, or fixed priority. An optional faction-round filter restricts the choice to requesters whose tag equals the current round tag. When none of them is asking, the round tag flips and the others are served at once.

Top module: `wh_port_alloc`

## Requirements
- R1: After reset `grant` is all zero and `busy` is low. Whenever `busy` is low, `grant` is zero.
- R2: `grant` is one-hot or zero. When `busy` is low and at least one requester presents a header flit, the grant appears after the next rising edge. It goes to a requester whose `req` is high, and `busy` rises on that same edge.
- R3: Flit kind is `flit_kind[2i+1:2i]`, encoded 2'b01 first, 2'b00 intermediate, 2'b10 last, 2'b11 single. Only first or single flits can take an idle port. An intermediate or last flit presented to an idle port yields no grant.
- R4: While locked, the grant stays on its owner through intermediate flits and through cycles without `flit_fire`, even if other requests arrive. On the edge where `flit_fire` is high and the owner shows a last flit, the lock is released: `busy` and `grant` are low after that edge, and a new grant may follow on the next edge. The owner keeps `req` high for as long as it holds the lock.
- R5: A single flit (2'b11) releases the lock on its own `flit_fire` cycle.
- R6: Round robin (`POLICY`=0): when a packet completes, the first-choice position moves to the index just after that packet's owner, searching upward with wrap. The position does not move on intermediate flits. With equal faction tags this plain policy applies.
- R7: Least recently served (`POLICY`=1): the eligible requester whose last completed packet is oldest wins. Before any completion, lower indices count as older.
- R8: Fixed priority (`POLICY`=2): the lowest-indexed eligible requester wins.
- R9: With `FACTION_EN`=1, a header requester whose tag equals the current round tag (0 after reset) wins over requesters with the other tag, whatever the base policy prefers.
- R10: With `FACTION_EN`=1, if no header requester carries the current round tag, the others are granted on the same edge with no idle cycle, and the round tag flips to the other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NREQ | Per-input request for the output port |
| flit_kind | input | 2*NREQ | Per-input head flit kind, two bits per input |
| faction_tag | input | NREQ | Per-input faction tag of the offered packet |
| flit_fire | input | 1 | The owner's flit is transferred this cycle |
| grant | output | NREQ | One-hot owner of the output port |
| busy | output | 1 | Port is locked by a packet |

## Verification
The bench drives three policy variants side by side with the same stimulus. Overlapping requests therefore expose whether each variant picks the round-robin successor, the least recently served input or the lowest index. Multi-flit packets that have other requests waiting show that the grant neither moves nor lets the round-robin pointer advance mid-packet. Single-flit packets show release on the same cycle. An idle port offered only body or tail flits must stay ungranted. Mixed-tag requests separate faction filtering from the base policy. A round with only other-tag requesters checks both the immediate grant and, through a later conflict, that the round tag really flipped.

// File: rtl/wh_alloc_pkg.sv
package wh_alloc_pkg;

    typedef enum logic [1:0] {
        FK_MID    = 2'b00,
        FK_FIRST  = 2'b01,
        FK_LAST   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOCKED = 1'b1
    } alloc_state_e;

    localparam int POL_RR    = 0;
    localparam int POL_LRU   = 1;
    localparam int POL_FIXED = 2;

    // bit 0 set: flit opens a packet (first or single)
    function automatic logic kind_is_head(input logic [1:0] k);
        return k[0];
    endfunction

    // bit 1 set: flit closes a packet (last or single)
    function automatic logic kind_is_tail(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/wh_fixed_pick.sv
module wh_fixed_pick #(
    parameter int NREQ = 4
) (
    input  logic [NREQ-1:0] elig,
    output logic [NREQ-1:0] pick
);
    always_comb begin
        pick = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wh_rr_pick.sv
module wh_rr_pick #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] elig,
    input  logic            upd,
    input  logic [NREQ-1:0] upd_oh,
    output logic [NREQ-1:0] pick
);
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] ptr_d;

    always_comb begin
        logic found;
        int   idx;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NREQ; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= NREQ) idx = idx - NREQ;
            if (!found && elig[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        if (upd) begin
            for (int i = 0; i < NREQ; i++) begin
                if (upd_oh[i]) ptr_d = (i == NREQ - 1) ? '0 : IW'(i + 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/wh_lru_pick.sv
module wh_lru_pick #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] elig,
    input  logic            upd,
    input  logic [NREQ-1:0] upd_oh,
    output logic [NREQ-1:0] pick
);
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

    // rank 0 is the oldest (most preferred) requester
    logic [IW-1:0] rank_q [NREQ];
    logic [IW-1:0] rank_d [NREQ];

    always_comb begin
        logic          found;
        logic [IW-1:0] best;
        int            sel;
        found = 1'b0;
        best  = '0;
        sel   = 0;
        for (int i = 0; i < NREQ; i++) begin
            if (elig[i] && (!found || rank_q[i] < best)) begin
                best  = rank_q[i];
                sel   = i;
                found = 1'b1;
            end
        end
        pick = '0;
        if (found) pick[sel] = 1'b1;
    end

    always_comb begin
        logic [IW-1:0] wrank;
        wrank = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (upd_oh[i]) wrank = rank_q[i];
        end
        for (int i = 0; i < NREQ; i++) begin
            rank_d[i] = rank_q[i];
            if (upd) begin
                if (upd_oh[i])             rank_d[i] = IW'(NREQ - 1);
                else if (rank_q[i] > wrank) rank_d[i] = rank_q[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREQ; i++) begin
            if (!rst_n) rank_q[i] <= IW'(i);
            else        rank_q[i] <= rank_d[i];
        end
    end
endmodule

// File: rtl/wh_port_alloc.sv
module wh_port_alloc
    import wh_alloc_pkg::*;
#(
    parameter int NREQ       = 4,
    parameter int POLICY     = POL_RR,
    parameter bit FACTION_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   req,
    input  logic [2*NREQ-1:0] flit_kind,
    input  logic [NREQ-1:0]   faction_tag,
    input  logic              flit_fire,
    output logic [NREQ-1:0]   grant,
    output logic              busy
);
    alloc_state_e    state_q, state_d;
    logic [NREQ-1:0] grant_q;
    logic [NREQ-1:0] head_req;
    logic [NREQ-1:0] tail_vec;
    logic [NREQ-1:0] elig;
    logic [NREQ-1:0] pick;
    logic            acquire;
    logic            release_pkt;
    logic            no_match;

    for (genvar i = 0; i < NREQ; i++) begin : g_kind
        assign head_req[i] = req[i] & kind_is_head(flit_kind[2*i +: 2]);
        assign tail_vec[i] = kind_is_tail(flit_kind[2*i +: 2]);
    end

    // faction-round filter
    if (FACTION_EN) begin : g_faction
        logic            round_tag_q;
        logic [NREQ-1:0] match;
        for (genvar i = 0; i < NREQ; i++) begin : g_m
            assign match[i] = head_req[i] & (faction_tag[i] == round_tag_q);
        end
        assign no_match = ~|match;
        assign elig     = no_match ? head_req : match;
        always_ff @(posedge clk) begin
            if (!rst_n)                   round_tag_q <= 1'b0;
            else if (acquire && no_match) round_tag_q <= ~round_tag_q;
        end
    end else begin : g_no_faction
        logic unused_tag;
        assign unused_tag = ^faction_tag;
        assign no_match   = 1'b0;
        assign elig       = head_req;
    end

    // base policy
    if (POLICY == POL_LRU) begin : g_lru
        wh_lru_pick #(.NREQ(NREQ)) u_pick (
            .clk(clk), .rst_n(rst_n), .elig(elig),
            .upd(release_pkt), .upd_oh(grant_q), .pick(pick));
    end else if (POLICY == POL_FIXED) begin : g_fixed
        wh_fixed_pick #(.NREQ(NREQ)) u_pick (.elig(elig), .pick(pick));
    end else begin : g_rr
        wh_rr_pick #(.NREQ(NREQ)) u_pick (
            .clk(clk), .rst_n(rst_n), .elig(elig),
            .upd(release_pkt), .upd_oh(grant_q), .pick(pick));
    end

    assign acquire     = (state_q == ST_IDLE) && (|elig);
    assign release_pkt = (state_q == ST_LOCKED) && flit_fire && (|(grant_q & tail_vec));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acquire)     state_d = ST_LOCKED;  // T_ACQUIRE
            ST_LOCKED: if (release_pkt) state_d = ST_IDLE;    // T_RELEASE
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (acquire)          grant_q <= pick;
            else if (release_pkt) grant_q <= '0;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_LOCKED: begin grant = grant_q; busy = 1'b1; end
            default:   begin grant = '0;      busy = 1'b0; end
        endcase
    end
endmodule

// File: rtl/wh_port_alloc_chk.sv
module wh_port_alloc_chk #(
    parameter int NREQ = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREQ-1:0]   req,
    input logic [2*NREQ-1:0] flit_kind,
    input logic              flit_fire,
    input logic [NREQ-1:0]   grant,
    input logic              busy
);
    logic [NREQ-1:0] headv;
    logic [NREQ-1:0] tailv;
    for (genvar i = 0; i < NREQ; i++) begin : g_v
        assign headv[i] = flit_kind[2*i];
        assign tailv[i] = flit_kind[2*i+1];
    end

    logic owner_tail;
    assign owner_tail = |(grant & tailv);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> grant == '0);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_acquire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && |(req & headv)) |=> busy);

    p_no_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(|(req & headv))) |=> !busy);

    p_owner_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> |(grant & req));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(flit_fire && owner_tail)) |=> (busy && $stable(grant)));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flit_fire && owner_tail) |=> !busy);
endmodule

bind wh_port_alloc wh_port_alloc_chk #(.NREQ(NREQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .flit_kind(flit_kind),
    .flit_fire(flit_fire), .grant(grant), .busy(busy));

// File: tb/wh_port_alloc_tb.sv
module wh_port_alloc_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req;
    logic [2*N-1:0] kind;
    logic [N-1:0] tag;
    logic         fire;
    logic [N-1:0] g_rr, g_lru, g_fix;
    logic         b_rr, b_lru, b_fix;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    wh_port_alloc #(.NREQ(N), .POLICY(0), .FACTION_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .flit_kind(kind),
        .faction_tag(tag), .flit_fire(fire), .grant(g_rr), .busy(b_rr));
    wh_port_alloc #(.NREQ(N), .POLICY(1), .FACTION_EN(1'b0)) u_dut_lru (
        .clk(clk), .rst_n(rst_n), .req(req), .flit_kind(kind),
        .faction_tag(tag), .flit_fire(fire), .grant(g_lru), .busy(b_lru));
    wh_port_alloc #(.NREQ(N), .POLICY(2), .FACTION_EN(1'b0)) u_dut_fix (
        .clk(clk), .rst_n(rst_n), .req(req), .flit_kind(kind),
        .faction_tag(tag), .flit_fire(fire), .grant(g_fix), .busy(b_fix));

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_kind(input logic [1:0] k);
        kind = {N{k}};
    endtask

    task automatic t_reset();
        chk("R1 reset grant rr", g_rr, 0);
        chk("R1 reset grant lru", g_lru, 0);
        chk("R1 reset grant fix", g_fix, 0);
        chk("R1 reset busy", {b_rr, b_lru, b_fix}, 0);
    endtask

    task automatic t_no_header();
        req = 4'b0001; set_kind(2'b00); tick();
        chk("R3 mid flit no grant", {g_rr, g_lru, g_fix}, 0);
        set_kind(2'b10); tick();
        chk("R3 last flit no grant", {b_rr, b_lru, b_fix}, 0);
        req = '0; tick();
    endtask

    task automatic t_packet();
        req = 4'b0110; set_kind(2'b01); tick();
        chk("R2 first grant rr", g_rr, 4'b0010);
        chk("R2 first grant lru", g_lru, 4'b0010);
        chk("R2 first grant fix", g_fix, 4'b0010);
        req = 4'b0111; set_kind(2'b00); fire = 1'b1; tick();
        chk("R4 hold on mid flit", {g_rr, g_lru, g_fix}, {3{4'b0010}});
        fire = 1'b0; tick();
        chk("R4 hold without fire", {g_rr, g_lru, g_fix}, {3{4'b0010}});
        set_kind(2'b10); fire = 1'b1; tick();
        chk("R4 released after last", {b_rr, b_lru, b_fix, g_rr}, 0);
        fire = 1'b0; set_kind(2'b01); tick();
        chk("R6 rr moves past winner", g_rr, 4'b0100);
        chk("R7 lru oldest wins", g_lru, 4'b0001);
        chk("R8 fixed lowest wins", g_fix, 4'b0001);
    endtask

    task automatic t_single();
        set_kind(2'b11); fire = 1'b1; tick();
        chk("R5 single releases", {b_rr, b_lru, b_fix}, 0);
        fire = 1'b0; tick();
        chk("R6 rr wraps to 0", g_rr, 4'b0001);
        chk("R7 lru picks 2", g_lru, 4'b0100);
        chk("R8 fixed picks 0", g_fix, 4'b0001);
        fire = 1'b1; tick();
        fire = 1'b0; req = '0; tick();
        chk("R5 idle after singles", {b_rr, b_lru, b_fix}, 0);
    endtask

    task automatic t_faction();
        req = 4'b0011; tag = 4'b0010; set_kind(2'b01); tick();
        chk("R9 current tag beats rr choice", g_rr, 4'b0001);
        set_kind(2'b11); fire = 1'b1; tick();
        fire = 1'b0; req = 4'b0110; tag = 4'b0110; set_kind(2'b01); tick();
        chk("R10 other tag granted at once", g_rr, 4'b0010);
        set_kind(2'b11); fire = 1'b1; tick();
        fire = 1'b0; req = 4'b0011; tag = 4'b0010; set_kind(2'b01); tick();
        chk("R10 round tag flipped", g_rr, 4'b0010);
        set_kind(2'b11); fire = 1'b1; tick();
        fire = 1'b0; req = '0; tick();
    endtask

    initial begin
        rst_n = 1'b0; req = '0; kind = '0; tag = '0; fire = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_no_header();
        t_packet();
        t_single();
        t_faction();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule